// File: doc/BRIEF.md
# VLAN Membership Table Engine

This block keeps the VLAN membership table of an Ethernet switch. It holds a fixed number of entries. Each entry carries a 13-bit VLAN identifier, a two-bit member code and a two-bit port-state code for every port, and a forwarding database number. Software reaches the table only through a small set of 16-bit registers. It stages an identifier, a valid flag, the per-port codes and a database number. It then writes an operation word with the busy bit set, and polls until busy reads zero.

Three operations are provided. Load/purge either installs an entry for the staged identifier or removes it. Get-next finds the next higher valid identifier. Flush empties the whole table.

Get-next leaves the identifier it found in the VID register. Repeated get-next commands therefore walk the table in ascending order without being reloaded in between. Load/purge and get-next visit one table slot per clock, so both take a fixed number of cycles. Flush clears the table in a single cycle.

Top module: `vlan_table_engine`

## Requirements
- R1: After reset, all registers read zero, busy is low and the table is empty, so a get-next from VID 0 finds nothing.
- R2: Writing address 0 with bit 15 set starts the operation named by bits [14:12]: opcode 1 is flush, 3 is load/purge and 4 is get-next. Busy (bit 15 of address 0, also the busy port) reads 1 from the next cycle on. For load/purge and get-next it clears DEPTH+1 clock edges after the starting write; for flush it clears 1 edge after.
- R3: While busy is 1, register writes to every address are ignored. This includes a write presented in the last busy cycle, which must not start a new operation.
- R4: The VID register (address 2'd1 of the 3-bit address, i.e. 1) holds the VID in bits [11:0], a page bit in bit 12 that forms VID bit 12, and the valid flag in bit 15. Bits 14:13 read zero.
- R5: Get-next searches for the smallest valid VID that is strictly greater than the VID register's 13-bit value. On a hit it writes that VID back with valid set, and loads the entry's port codes into the data registers and its database number into the operation register.
- R6: When no valid VID above the key exists, get-next clears the valid bit and leaves the VID bits, the data registers and the database field unchanged.
- R7: Issuing get-next repeatedly without rewriting the VID register visits every valid entry once, in ascending VID order, and then reports not-found.
- R8: Load/purge with the valid bit set installs the entry for that VID. If the VID is already present, its port codes and database number are overwritten and no second copy is made.
- R9: Load/purge with the valid bit clear removes the entry for that VID. Other entries are unaffected.
- R10: Port p uses the nibble at bits [4*(p mod 4)+3 : 4*(p mod 4)] of the data register at address 2 + p/4. Within a nibble, bits [1:0] are the member code and bits [3:2] are the port-state code. With 12 ports the data registers are at addresses 2, 3 and 4.
- R11: The database number is 8 bits. Its low nibble is in operation-register bits [3:0] and its high nibble in bits [11:8]. It is masked to the supported count of NUM_DB = 64, so bits 7:6 always read back as zero.
- R12: Flush invalidates every entry.
- R13: When all DEPTH slots hold valid entries, loading a new VID changes nothing. A load of a VID that is already present still overwrites that entry.
- R14: A write to address 0 with bit 15 clear starts no operation: busy stays low and the table is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address for both reads and writes |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data, combinational from reg_addr |
| busy | output | 1 | Operation in progress, same as bit 15 of address 0 |

## Verification
Two functions can fall in the same cycle: the engine's completion, which clears busy and writes the get-next result into the registers, and a software write to the operation register. The bench counts exactly DEPTH clocks after starting a get-next. It then presents a flush command during the single completion cycle, while busy still reads 1.

The result is judged at the ports. Busy must read 0 on the next cycle, the VID register must hold the get-next result rather than anything the write carried, and a later full walk must still find every entry. Such a walk would be empty if the flush had been taken. Writes to the VID and data registers made in the middle of a scan are judged the same way.

// File: rtl/vte_pkg.sv
package vte_pkg;

  localparam int VID_W     = 13;
  localparam int BUSY_BIT  = 15;
  localparam int VALID_BIT = 15;

  localparam logic [2:0] RA_OPER = 3'd0;
  localparam logic [2:0] RA_VID  = 3'd1;
  localparam int         RA_DATA = 2;

  localparam logic [2:0] OPC_FLUSH     = 3'd1;
  localparam logic [2:0] OPC_LOADPURGE = 3'd3;
  localparam logic [2:0] OPC_GETNEXT   = 3'd4;

  // database number sits split across the operation word
  function automatic logic [7:0] db_from_oper(logic [15:0] w);
    return {w[11:8], w[3:0]};
  endfunction

  function automatic logic [15:0] oper_word(logic bsy, logic [2:0] opc, logic [7:0] db);
    return {bsy, opc, db[7:4], 4'b0000, db[3:0]};
  endfunction

  function automatic logic [15:0] vid_word(logic vld, logic [VID_W-1:0] vid);
    return {vld, 2'b00, vid};
  endfunction

  // true when a slot improves the current get-next candidate
  function automatic logic gn_better(logic vld, logic [VID_W-1:0] vid,
                                     logic [VID_W-1:0] key, logic have,
                                     logic [VID_W-1:0] best);
    return vld && (vid > key) && (!have || (vid < best));
  endfunction

endpackage

// File: rtl/vte_store.sv
module vte_store
  import vte_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int PW    = 48,
  parameter int DB_W  = 6,
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             wr_en,
  input  logic [IW-1:0]    wr_idx,
  input  logic             wr_vld,
  input  logic [VID_W-1:0] wr_vid,
  input  logic [PW-1:0]    wr_ports,
  input  logic [DB_W-1:0]  wr_db,
  input  logic [IW-1:0]    rd_idx,
  output logic             rd_vld,
  output logic [VID_W-1:0] rd_vid,
  output logic [PW-1:0]    rd_ports,
  output logic [DB_W-1:0]  rd_db,
  output logic             any_valid
);

  logic [DEPTH-1:0] vld_q;
  logic [VID_W-1:0] vid_m   [DEPTH];
  logic [PW-1:0]    ports_m [DEPTH];
  logic [DB_W-1:0]  db_m    [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
    end else if (flush) begin
      vld_q <= '0;
    end else if (wr_en) begin
      vld_q[wr_idx] <= wr_vld;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      vid_m[wr_idx]   <= wr_vid;
      ports_m[wr_idx] <= wr_ports;
      db_m[wr_idx]    <= wr_db;
    end
  end

  assign rd_vld    = vld_q[rd_idx];
  assign rd_vid    = vid_m[rd_idx];
  assign rd_ports  = ports_m[rd_idx];
  assign rd_db     = db_m[rd_idx];
  assign any_valid = |vld_q;

  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !any_valid); // R12

endmodule

// File: rtl/vte_scan.sv
module vte_scan
  import vte_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [2:0]       start_opc,
  input  logic [VID_W-1:0] key_vid,
  input  logic             ent_vld,
  input  logic [VID_W-1:0] ent_vid,
  output logic [IW-1:0]    look_idx,
  output logic             done,
  output logic [2:0]       done_opc,
  output logic             hit,
  output logic [IW-1:0]    hit_idx,
  output logic [VID_W-1:0] hit_vid,
  output logic             free_ok,
  output logic [IW-1:0]    free_idx
);

  typedef enum logic [1:0] {SC_IDLE, SC_RUN, SC_DONE} sc_state_e;
  localparam logic [IW-1:0] LAST = IW'(DEPTH - 1);

  sc_state_e        st_q;
  logic [IW-1:0]    idx_q, hit_idx_q, free_idx_q;
  logic [2:0]       opc_q;
  logic             hit_q, free_q;
  logic [VID_W-1:0] hit_vid_q;
  logic             upd_hit, upd_free;

  always_comb begin
    upd_hit = 1'b0;
    if (st_q == SC_RUN) begin
      if (opc_q == OPC_GETNEXT)
        upd_hit = gn_better(ent_vld, ent_vid, key_vid, hit_q, hit_vid_q);
      else
        upd_hit = ent_vld && (ent_vid == key_vid);
    end
  end

  assign upd_free = (st_q == SC_RUN) && (opc_q == OPC_LOADPURGE) && !ent_vld && !free_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= SC_IDLE;
      idx_q      <= '0;
      opc_q      <= '0;
      hit_q      <= 1'b0;
      hit_idx_q  <= '0;
      hit_vid_q  <= '0;
      free_q     <= 1'b0;
      free_idx_q <= '0;
    end else begin
      case (st_q)
        SC_IDLE: if (start) begin
          opc_q  <= start_opc;
          idx_q  <= '0;
          hit_q  <= 1'b0;
          free_q <= 1'b0;
          st_q   <= (start_opc == OPC_GETNEXT || start_opc == OPC_LOADPURGE) ? SC_RUN : SC_DONE;
        end
        SC_RUN: begin
          if (upd_hit) begin
            hit_q     <= 1'b1;
            hit_idx_q <= idx_q;
            hit_vid_q <= ent_vid;
          end
          if (upd_free) begin
            free_q     <= 1'b1;
            free_idx_q <= idx_q;
          end
          idx_q <= idx_q + 1'b1;
          if (idx_q == LAST) st_q <= SC_DONE;
        end
        default: st_q <= SC_IDLE;
      endcase
    end
  end

  assign look_idx = (st_q == SC_DONE) ? hit_idx_q : idx_q;
  assign done     = (st_q == SC_DONE);
  assign done_opc = opc_q;
  assign hit      = hit_q;
  assign hit_idx  = hit_idx_q;
  assign hit_vid  = hit_vid_q;
  assign free_ok  = free_q;
  assign free_idx = free_idx_q;

  AST_SCAN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == SC_RUN && idx_q != LAST) |=> (idx_q == $past(idx_q) + 1'b1)); // R2
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R2

endmodule

// File: rtl/vte_regs.sv
module vte_regs
  import vte_pkg::*;
#(
  parameter int NUM_PORTS = 12,
  parameter int DB_W      = 6
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   reg_wr,
  input  logic [2:0]             reg_addr,
  input  logic [15:0]            reg_wdata,
  output logic [15:0]            reg_rdata,
  input  logic                   eng_done,
  input  logic [2:0]             eng_opc,
  input  logic                   gn_found,
  input  logic [VID_W-1:0]       gn_vid,
  input  logic [4*NUM_PORTS-1:0] gn_ports,
  input  logic [DB_W-1:0]        gn_db,
  output logic                   busy,
  output logic                   start,
  output logic [2:0]             start_opc,
  output logic [VID_W-1:0]       vid_key,
  output logic                   vid_vld,
  output logic [4*NUM_PORTS-1:0] ports,
  output logic [DB_W-1:0]        db
);

  logic                   busy_q, vvld_q;
  logic [2:0]             opc_q;
  logic [DB_W-1:0]        db_q;
  logic [VID_W-1:0]       vid_q;
  logic [4*NUM_PORTS-1:0] ports_q;
  logic                   acc, oper_wr;

  assign acc     = reg_wr && !busy_q;
  assign oper_wr = acc && (reg_addr == RA_OPER);
  assign start   = oper_wr && reg_wdata[BUSY_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      opc_q   <= '0;
      db_q    <= '0;
      vid_q   <= '0;
      vvld_q  <= 1'b0;
      ports_q <= '0;
    end else begin
      if (oper_wr) begin
        busy_q <= reg_wdata[BUSY_BIT];
        opc_q  <= reg_wdata[14:12];
        db_q   <= DB_W'(db_from_oper(reg_wdata));
      end
      if (acc && reg_addr == RA_VID) begin
        vid_q  <= reg_wdata[VID_W-1:0];
        vvld_q <= reg_wdata[VALID_BIT];
      end
      for (int p = 0; p < NUM_PORTS; p++) begin
        if (acc && reg_addr == 3'(RA_DATA + p / 4))
          ports_q[4*p +: 4] <= reg_wdata[4*(p % 4) +: 4];
      end
      if (eng_done) begin
        busy_q <= 1'b0;
        if (eng_opc == OPC_GETNEXT) begin
          vvld_q <= gn_found;
          if (gn_found) begin
            vid_q   <= gn_vid;
            ports_q <= gn_ports;
            db_q    <= gn_db;
          end
        end
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      RA_OPER: reg_rdata = oper_word(busy_q, opc_q, 8'(db_q));
      RA_VID:  reg_rdata = vid_word(vvld_q, vid_q);
      default: begin
        for (int p = 0; p < NUM_PORTS; p++) begin
          if (reg_addr == 3'(RA_DATA + p / 4))
            reg_rdata[4*(p % 4) +: 4] = ports_q[4*p +: 4];
        end
      end
    endcase
  end

  assign busy      = busy_q;
  assign start_opc = reg_wdata[14:12];
  assign vid_key   = vid_q;
  assign vid_vld   = vvld_q;
  assign ports     = ports_q;
  assign db        = db_q;

  AST_WR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && reg_wr && !eng_done) |=>
      ($stable(vid_q) && $stable(vvld_q) && $stable(ports_q) && $stable(opc_q) && $stable(db_q))); // R3
  AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !eng_done) |=> busy_q); // R2
  AST_MISS_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_done && eng_opc == OPC_GETNEXT && !gn_found) |=> (!vvld_q && $stable(vid_q))); // R6

endmodule

// File: rtl/vlan_table_engine.sv
module vlan_table_engine
  import vte_pkg::*;
#(
  parameter int NUM_PORTS = 12,
  parameter int DEPTH     = 64,
  parameter int NUM_DB    = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [2:0]  reg_addr,
  input  logic [15:0] reg_wdata,
  output logic [15:0] reg_rdata,
  output logic        busy
);

  localparam int IW   = $clog2(DEPTH);
  localparam int PW   = 4 * NUM_PORTS;
  localparam int DB_W = $clog2(NUM_DB);

  logic             start, vid_vld, done, hit, free_ok;
  logic [2:0]       start_opc, done_opc;
  logic [VID_W-1:0] vid_key, hit_vid;
  logic [PW-1:0]    ports;
  logic [DB_W-1:0]  db;
  logic [IW-1:0]    look_idx, hit_idx, free_idx;
  logic             ent_vld, any_valid;
  logic [VID_W-1:0] ent_vid;
  logic [PW-1:0]    ent_ports;
  logic [DB_W-1:0]  ent_db;

  // internal events, named for the assertions
  logic flush_now, lp_done, gn_done, lp_write;

  assign flush_now = start && (start_opc == OPC_FLUSH);
  assign lp_done   = done && (done_opc == OPC_LOADPURGE);
  assign gn_done   = done && (done_opc == OPC_GETNEXT);
  assign lp_write  = lp_done && (hit || (vid_vld && free_ok));

  vte_regs #(.NUM_PORTS(NUM_PORTS), .DB_W(DB_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .eng_done(done), .eng_opc(done_opc), .gn_found(hit), .gn_vid(ent_vid),
    .gn_ports(ent_ports), .gn_db(ent_db),
    .busy(busy), .start(start), .start_opc(start_opc), .vid_key(vid_key),
    .vid_vld(vid_vld), .ports(ports), .db(db)
  );

  vte_scan #(.DEPTH(DEPTH)) u_scan (
    .clk(clk), .rst_n(rst_n), .start(start), .start_opc(start_opc),
    .key_vid(vid_key), .ent_vld(ent_vld), .ent_vid(ent_vid),
    .look_idx(look_idx), .done(done), .done_opc(done_opc), .hit(hit),
    .hit_idx(hit_idx), .hit_vid(hit_vid), .free_ok(free_ok), .free_idx(free_idx)
  );

  vte_store #(.DEPTH(DEPTH), .PW(PW), .DB_W(DB_W)) u_store (
    .clk(clk), .rst_n(rst_n), .flush(flush_now), .wr_en(lp_write),
    .wr_idx(hit ? hit_idx : free_idx), .wr_vld(vid_vld), .wr_vid(vid_key),
    .wr_ports(ports), .wr_db(db), .rd_idx(look_idx),
    .rd_vld(ent_vld), .rd_vid(ent_vid), .rd_ports(ent_ports), .rd_db(ent_db),
    .any_valid(any_valid)
  );

  AST_GN_ABOVE_KEY: assert property (@(posedge clk) disable iff (!rst_n)
    (gn_done && hit) |-> (hit_vid > vid_key)); // R5
  AST_DONE_FREES: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy); // R2
  AST_FULL_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (lp_done && !hit && !free_ok) |=> $stable(any_valid)); // R13
  AST_START_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy); // R2

endmodule

// File: tb/vlan_table_engine_bench.sv
module vlan_table_engine_bench;

  localparam int NP = 12;
  localparam int DEPTH = 64;
  localparam int OP_FL = 1;
  localparam int OP_LP = 3;
  localparam int OP_GN = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        busy;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  logic            m_vld   [DEPTH];
  logic [12:0]     m_vid   [DEPTH];
  logic [4*NP-1:0] m_ports [DEPTH];
  logic [5:0]      m_db    [DEPTH];

  vlan_table_engine u_vlan_table_engine (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .busy(busy)
  );

  always #10 clk = ~clk;

  function automatic logic [15:0] e_oper(logic b, int opc, logic [7:0] db);
    return (16'(b) << 15) | (16'(opc) << 12) | (16'(db >> 4) << 8) | 16'(db & 8'h0F);
  endfunction

  function automatic logic [15:0] e_vid(logic v, logic [12:0] vid);
    return (16'(v) << 15) | 16'(vid);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic wait_idle();
    for (int g = 0; g < 1000 && busy; g++) @(negedge clk);
  endtask

  task automatic run_op(input int opc, input logic [7:0] db);
    int cyc;
    wr(3'd0, e_oper(1'b1, opc, db));
    cyc = 0;
    while (busy && cyc < 1000) begin
      cyc++;
      @(negedge clk);
    end
    chk("R2 busy length", cyc, (opc == OP_FL) ? 1 : DEPTH + 1);
  endtask

  function automatic void m_load(logic v, logic [12:0] vid, logic [4*NP-1:0] p, logic [7:0] db);
    int hit = -1;
    int fr = -1;
    for (int i = 0; i < DEPTH; i++) begin
      if (m_vld[i] && m_vid[i] == vid) hit = i;
      if (!m_vld[i] && fr < 0) fr = i;
    end
    if (!v) begin
      if (hit >= 0) m_vld[hit] = 1'b0;
    end else begin
      if (hit < 0) hit = fr;
      if (hit >= 0) begin
        m_vld[hit] = 1'b1; m_vid[hit] = vid; m_ports[hit] = p; m_db[hit] = db[5:0];
      end
    end
  endfunction

  function automatic int m_next(logic [12:0] key);
    int best = -1;
    for (int i = 0; i < DEPTH; i++)
      if (m_vld[i] && m_vid[i] > key && (best < 0 || m_vid[i] < m_vid[best])) best = i;
    return best;
  endfunction

  task automatic ld(input logic v, input logic [12:0] vid, input logic [4*NP-1:0] p, input logic [7:0] db);
    wr(3'd1, e_vid(v, vid));
    for (int k = 0; k < 3; k++) wr(3'(2 + k), p[16*k +: 16]);
    run_op(OP_LP, db);
    m_load(v, vid, p, db);
  endtask

  task automatic walk(input logic [12:0] start, input string req);
    logic [12:0] key;
    logic [15:0] d;
    int b;
    key = start;
    wr(3'd1, e_vid(1'b0, key));
    for (int it = 0; it < DEPTH + 2; it++) begin
      run_op(OP_GN, 8'h00);
      b = m_next(key);
      rd(3'd1, d);
      chk(req, d, (b >= 0) ? e_vid(1'b1, m_vid[b]) : e_vid(1'b0, key));
      if (b < 0) break;
      for (int k = 0; k < 3; k++) begin
        rd(3'(2 + k), d);
        chk("R10 port nibbles", d, m_ports[b][16*k +: 16]);
      end
      rd(3'd0, d);
      chk("R11 database field", d, e_oper(1'b0, OP_GN, 8'(m_db[b])));
      key = m_vid[b];
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    logic [4*NP-1:0] pr;
    int b;
    for (int i = 0; i < DEPTH; i++) m_vld[i] = 1'b0;
    void'($urandom(32'h0BADC0DE));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 5; a++) begin
      rd(3'(a), d);
      chk("R1 register reset", d, 0);
    end
    chk("R1 busy after reset", busy, 0);
    walk(13'd0, "R1 empty table");

    // directed loads, page bit and database masking
    ld(1'b1, 13'd5, 48'h1234_5678_9ABC, 8'hFF);
    ld(1'b1, 13'h1000, 48'hFEDC_BA98_7654, 8'h3A);
    ld(1'b1, 13'd100, 48'h0F0F_F0F0_5A5A, 8'hC7);
    wr(3'd1, e_vid(1'b1, 13'h1ABC));
    rd(3'd1, d);
    chk("R4 VID register layout", d, 16'h9ABC);
    walk(13'd0, "R7 ascending walk");
    walk(13'd100, "R5 strictly greater");

    // R3 writes in the middle of a scan
    wr(3'd1, e_vid(1'b0, 13'd5));
    wr(3'd0, e_oper(1'b1, OP_GN, 8'h00));
    chk("R2 busy set", busy, 1);
    wr(3'd1, e_vid(1'b1, 13'h1FFF));
    wr(3'd2, 16'hFFFF);
    wr(3'd0, e_oper(1'b1, OP_FL, 8'hFF));
    wait_idle();
    b = m_next(13'd5);
    rd(3'd1, d);
    chk("R3 VID write ignored", d, e_vid(1'b1, m_vid[b]));
    rd(3'd2, d);
    chk("R3 data write ignored", d, m_ports[b][15:0]);

    // R3 collision with the completion cycle
    wr(3'd1, e_vid(1'b0, 13'd0));
    wr(3'd0, e_oper(1'b1, OP_GN, 8'h00));
    repeat (DEPTH) @(negedge clk);
    chk("R2 busy in completion cycle", busy, 1);
    reg_wr = 1'b1; reg_addr = 3'd0; reg_wdata = e_oper(1'b1, OP_FL, 8'h00);
    @(negedge clk);
    reg_wr = 1'b0;
    chk("R3 late command not started", busy, 0);
    b = m_next(13'd0);
    rd(3'd1, d);
    chk("R3 result kept", d, e_vid(1'b1, m_vid[b]));
    walk(13'd0, "R3 table intact");

    // R9 purge, R8 overwrite
    ld(1'b0, 13'd100, 48'h0, 8'h00);
    ld(1'b1, 13'd5, 48'hAAAA_5555_0001, 8'h12);
    walk(13'd0, "R9 R8 purge and overwrite");

    // R14 command without busy bit
    wr(3'd0, e_oper(1'b0, OP_FL, 8'h00));
    chk("R14 no start", busy, 0);
    walk(13'd0, "R14 table unchanged");

    // random mix
    for (int n = 0; n < 40; n++) begin
      pr = {16'($urandom), 32'($urandom)};
      ld(($urandom % 4) != 0, 13'((($urandom % 12) * 613) % 8192), pr, 8'($urandom));
    end
    walk(13'd0, "R8 random walk");
    walk(13'd2000, "R5 random mid key");

    // R12 flush
    run_op(OP_FL, 8'h00);
    for (int i = 0; i < DEPTH; i++) m_vld[i] = 1'b0;
    walk(13'd0, "R12 flushed");

    // R13 full table
    for (int i = 1; i <= DEPTH; i++) ld(1'b1, 13'(i * 3), 48'(i), 8'(i));
    ld(1'b1, 13'd1, 48'hDEAD, 8'h01);
    ld(1'b1, 13'd30, 48'hBEEF, 8'h05);
    walk(13'd0, "R13 full table");
    wr(3'd1, e_vid(1'b0, 13'd0));
    run_op(OP_GN, 8'h00);
    rd(3'd1, d);
    chk("R13 new VID rejected", d, e_vid(1'b1, 13'd3));

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

endmodule